// File: doc/BRIEF.md
# Host Channel Enable/Disable Control

This block keeps the characteristics word for each channel of a full-speed host controller with nine channels. Software writes a channel's word over a simple register port. Each word holds a device address, a transaction count per frame, a periodic flag, an odd/even frame selector, and two control bits. Software can only set the two control bits. The first bit starts the channel. The second bit asks for an abort while the channel is running.

The transfer engine reports through `xfer_end` that a channel has stopped, either because its transfer finished or because an abort took effect. The block then clears the channel's control bits and raises a one-cycle halted interrupt for that channel. While a channel is active, the block shows the engine a start request. For periodic channels the request is gated by the parity of the current frame number, and it is limited to the channel's transaction count for each frame. The engine takes one transaction by pulsing `start_ack` while the request is high.

Top module: `hc_chan_ctrl`

## Requirements
- R1: After reset, every channel word reads 0, and all start requests and halted interrupts are low.
- R2: Writing a word with bit 31 set sets that channel's enable. Writing 0 to bit 31 leaves it unchanged. Only an accepted `xfer_end` clears it.
- R3: Writing bit 30 (abort) sets the abort bit only when the channel is enabled and no `xfer_end` arrives in the same cycle. On an idle channel the write is ignored, and bit 30 reads back 0.
- R4: An `xfer_end` on an enabled channel that has an abort pending clears bits 31 and 30 at the same clock edge. At that edge the channel's `halt_irq` goes high for exactly one cycle.
- R5: An `xfer_end` on an enabled channel with no abort pending also clears bit 31 and pulses `halt_irq` for one cycle. An `xfer_end` on a channel that is not enabled has no effect.
- R6: Write data bit 29 is the odd-frame select (1 = odd), bits 28:22 the device address, bits 21:20 the multi count and bit 19 the periodic flag. All of these read back as written, and all other read bits are 0.
- R7: A non-periodic channel (bit 19 = 0) holds `start_req` high while it is enabled and has no abort pending.
- R8: A periodic channel raises `start_req` only while `frame_num[0]` equals its odd-frame bit.
- R9: A periodic channel accepts at most 1, 2 or 3 transactions per frame, for multi count 01, 10 and 11. A count of 00 acts as 1. The budget refills when `frame_num` changes.
- R10: A pending abort drops `start_req` from the cycle after the abort write.
- R11: A write to one channel leaves every other channel's word unchanged.
- R12: Writes to a channel index of 9 or more are ignored, and reading such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 4 | Channel index for the write |
| wr_data | input | 32 | Write data |
| rd_ch | input | 4 | Channel index for the read |
| rd_data | output | 32 | Combinational read of the selected word |
| frame_num | input | 11 | Current frame number |
| xfer_end | input | 9 | Per-channel "engine stopped this channel" pulse |
| start_ack | input | 9 | Per-channel "engine took one transaction" pulse |
| start_req | output | 9 | Per-channel start request to the engine |
| halt_irq | output | 9 | Per-channel one-cycle halted interrupt |

## Verification
The bench drives an abort followed by the engine's stop report. It checks that both control bits clear at the same edge and that the interrupt lasts exactly one cycle; a design that cleared only the enable bit, or held the interrupt, would fail there. It writes zero to the enable bit and writes an abort to an idle channel, to catch control bits that software could clear or set freely. It steps frame parity and counts acknowledged transactions against multi counts of 3 and 0, which exposes an off-by-one budget, a budget that never refills, or a reserved count that blocks the channel. Writes to a channel index beyond the last channel catch address decoding that aliases onto a real channel.

// File: rtl/hc_pkg.sv
package hc_pkg;

    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 7;
    localparam int MC_W     = 2;

    localparam int EN_BIT   = 31;
    localparam int ABT_BIT  = 30;
    localparam int ODD_BIT  = 29;
    localparam int ADDR_LSB = 22;
    localparam int MC_LSB   = 20;
    localparam int PER_BIT  = 19;

    typedef struct packed {
        logic              odd;
        logic [ADDR_W-1:0] dev_addr;
        logic [MC_W-1:0]   mcount;
        logic              periodic;
    } chan_cfg_t;

endpackage

// File: rtl/hc_chan_slot.sv
module hc_chan_slot
    import hc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              xfer_end,
    input  logic              start_ack,
    input  logic              new_frame,
    input  logic              frame_lsb,
    output logic              en,
    output logic              abt,
    output chan_cfg_t         cfg,
    output logic              start_req,
    output logic              halt_irq
);

    typedef struct packed {
        logic            en;
        logic            abt;
        logic            irq;
        logic [MC_W-1:0] used;
        chan_cfg_t       cfg;
    } slot_t;

    slot_t st_d, st_q;

    logic [MC_W-1:0] budget;
    logic [MC_W-1:0] used_base;
    logic            parity_ok;
    logic            budget_ok;
    logic            req;

    always_comb begin
        budget    = (st_q.cfg.mcount == '0) ? MC_W'(1) : st_q.cfg.mcount;
        used_base = new_frame ? '0 : st_q.used;
        parity_ok = !st_q.cfg.periodic || (frame_lsb == st_q.cfg.odd);
        budget_ok = !st_q.cfg.periodic || (used_base < budget);
        req       = st_q.en && !st_q.abt && parity_ok && budget_ok;

        st_d      = st_q;
        st_d.irq  = 1'b0;
        st_d.used = used_base + MC_W'(req && start_ack && st_q.cfg.periodic);

        if (xfer_end && st_q.en) begin
            st_d.en   = 1'b0;
            st_d.abt  = 1'b0;
            st_d.irq  = 1'b1;
            st_d.used = '0;
        end

        if (wr_hit) begin
            st_d.cfg.odd      = wr_data[ODD_BIT];
            st_d.cfg.dev_addr = wr_data[ADDR_LSB +: ADDR_W];
            st_d.cfg.mcount   = wr_data[MC_LSB +: MC_W];
            st_d.cfg.periodic = wr_data[PER_BIT];
            if (wr_data[EN_BIT]) begin
                st_d.en = 1'b1;
            end
            if (wr_data[ABT_BIT] && st_q.en && !xfer_end) begin
                st_d.abt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en        = st_q.en;
    assign abt       = st_q.abt;
    assign cfg       = st_q.cfg;
    assign start_req = req;
    assign halt_irq  = st_q.irq;

endmodule

// File: rtl/hc_rd_mux.sv
module hc_rd_mux
    import hc_pkg::*;
#(
    parameter int NCH  = 9,
    parameter int CH_W = 4
) (
    input  logic [CH_W-1:0]   sel,
    input  logic [NCH-1:0]    en_vec,
    input  logic [NCH-1:0]    abt_vec,
    input  chan_cfg_t         cfg_arr [NCH],
    output logic [WORD_W-1:0] word
);

    always_comb begin
        word = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel == CH_W'(i)) begin
                word[EN_BIT]                = en_vec[i];
                word[ABT_BIT]               = abt_vec[i];
                word[ODD_BIT]               = cfg_arr[i].odd;
                word[ADDR_LSB +: ADDR_W]    = cfg_arr[i].dev_addr;
                word[MC_LSB +: MC_W]        = cfg_arr[i].mcount;
                word[PER_BIT]               = cfg_arr[i].periodic;
            end
        end
    end

endmodule

// File: rtl/hc_chan_ctrl.sv
module hc_chan_ctrl
    import hc_pkg::*;
#(
    parameter int NCH  = 9,
    parameter int CH_W = 4,
    parameter int FN_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [31:0]       wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [31:0]       rd_data,
    input  logic [FN_W-1:0]   frame_num,
    input  logic [NCH-1:0]    xfer_end,
    input  logic [NCH-1:0]    start_ack,
    output logic [NCH-1:0]    start_req,
    output logic [NCH-1:0]    halt_irq
);

    typedef struct packed {
        logic [FN_W-1:0] frame;
    } top_t;

    top_t top_d, top_q;

    logic             new_frame;
    logic [NCH-1:0]   en_vec;
    logic [NCH-1:0]   abt_vec;
    logic [NCH-1:0]   per_vec;
    logic [NCH-1:0]   odd_vec;
    chan_cfg_t        cfg_arr [NCH];

    always_comb begin
        top_d       = top_q;
        top_d.frame = frame_num;
        new_frame   = (frame_num != top_q.frame);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_ch == CH_W'(g));

        hc_chan_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (hit),
            .wr_data   (wr_data),
            .xfer_end  (xfer_end[g]),
            .start_ack (start_ack[g]),
            .new_frame (new_frame),
            .frame_lsb (frame_num[0]),
            .en        (en_vec[g]),
            .abt       (abt_vec[g]),
            .cfg       (cfg_arr[g]),
            .start_req (start_req[g]),
            .halt_irq  (halt_irq[g])
        );

        assign per_vec[g] = cfg_arr[g].periodic;
        assign odd_vec[g] = cfg_arr[g].odd;
    end

    hc_rd_mux #(.NCH(NCH), .CH_W(CH_W)) u_rd (
        .sel     (rd_ch),
        .en_vec  (en_vec),
        .abt_vec (abt_vec),
        .cfg_arr (cfg_arr),
        .word    (rd_data)
    );

endmodule

// File: rtl/hc_chan_ctrl_chk.sv
module hc_chan_ctrl_chk #(
    parameter int NCH = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] en_vec,
    input logic [NCH-1:0] abt_vec,
    input logic [NCH-1:0] per_vec,
    input logic [NCH-1:0] odd_vec,
    input logic [NCH-1:0] xfer_end,
    input logic [NCH-1:0] start_req,
    input logic [NCH-1:0] halt_irq,
    input logic           frame_lsb
);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            halt_irq[g] |=> !halt_irq[g]); // R4

        AST_END_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_end[g] && en_vec[g]) |=> halt_irq[g]); // R5

        AST_EN_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(en_vec[g]) |-> $past(xfer_end[g])); // R2

        AST_ABT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(abt_vec[g]) |-> en_vec[g]); // R3

        AST_ABT_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            abt_vec[g] |-> !start_req[g]); // R10

        AST_PARITY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            (start_req[g] && per_vec[g]) |-> (frame_lsb == odd_vec[g])); // R8
    end

endmodule

bind hc_chan_ctrl hc_chan_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_vec    (en_vec),
    .abt_vec   (abt_vec),
    .per_vec   (per_vec),
    .odd_vec   (odd_vec),
    .xfer_end  (xfer_end),
    .start_req (start_req),
    .halt_irq  (halt_irq),
    .frame_lsb (frame_num[0])
);

// File: tb/tb_hc_chan_ctrl.sv
module tb_hc_chan_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 9;
    localparam int CH_W = 4;
    localparam int FN_W = 11;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [CH_W-1:0]   wr_ch;
    logic [31:0]       wr_data;
    logic [CH_W-1:0]   rd_ch;
    logic [31:0]       rd_data;
    logic [FN_W-1:0]   frame_num;
    logic [NCH-1:0]    xfer_end;
    logic [NCH-1:0]    start_ack;
    logic [NCH-1:0]    start_req;
    logic [NCH-1:0]    halt_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hc_chan_ctrl #(.NCH(NCH), .CH_W(CH_W), .FN_W(FN_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_data   (wr_data),
        .rd_ch     (rd_ch),
        .rd_data   (rd_data),
        .frame_num (frame_num),
        .xfer_end  (xfer_end),
        .start_ack (start_ack),
        .start_req (start_req),
        .halt_irq  (halt_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int ch, input logic [31:0] d);
        wr_en = 1'b1; wr_ch = CH_W'(ch); wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input int ch, output logic [31:0] d);
        rd_ch = CH_W'(ch);
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int c = 0; c < NCH; c++) begin
            rd(c, v);
            check("R1 word after reset", v, 32'h0);
        end
        check("R1 start_req after reset", 32'(start_req), 32'h0);
        check("R1 halt_irq after reset", 32'(halt_irq), 32'h0);
    endtask

    task automatic t_enable_set_only();
        logic [31:0] v;
        wr(0, 32'h8000_0000);
        rd(0, v);
        check("R2 enable set", 32'(v[31]), 32'h1);
        check("R7 non-periodic request", 32'(start_req[0]), 32'h1);
        wr(0, 32'h0000_0000);
        rd(0, v);
        check("R2 zero write keeps enable", 32'(v[31]), 32'h1);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        wr(3, 32'h2000_0000 | (32'h55 << 22) | (32'h2 << 20) | 32'h0008_0000 | 32'h0000_FFFF);
        rd(3, v);
        check("R6 field readback", v, 32'h2000_0000 | (32'h55 << 22) | (32'h2 << 20) | 32'h0008_0000);
    endtask

    task automatic t_abort_idle();
        logic [31:0] v;
        wr(5, 32'h4000_0000);
        rd(5, v);
        check("R3 abort on idle ignored", v, 32'h0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        wr(0, 32'h4000_0000);
        rd(0, v);
        check("R3 abort bit set", v[31:30], 32'h3);
        check("R10 abort drops request", 32'(start_req[0]), 32'h0);
        xfer_end[0] = 1'b1;
        step();
        xfer_end[0] = 1'b0;
        rd(0, v);
        check("R4 both bits cleared", 32'(v[31:30]), 32'h0);
        check("R4 halt irq raised", 32'(halt_irq[0]), 32'h1);
        step();
        check("R4 halt irq one cycle", 32'(halt_irq[0]), 32'h0);
    endtask

    task automatic t_complete();
        logic [31:0] v;
        xfer_end[6] = 1'b1;
        step();
        xfer_end[6] = 1'b0;
        check("R5 end on idle channel no irq", 32'(halt_irq[6]), 32'h0);
        wr(1, 32'h8000_0000);
        xfer_end[1] = 1'b1;
        step();
        xfer_end[1] = 1'b0;
        rd(1, v);
        check("R5 enable cleared on completion", 32'(v[31]), 32'h0);
        check("R5 irq on completion", 32'(halt_irq[1]), 32'h1);
        step();
    endtask

    task automatic t_parity();
        frame_num = 11'd0;
        wr(2, 32'h8000_0000 | 32'h2000_0000 | (32'h1 << 20) | 32'h0008_0000);
        check("R8 even frame blocks odd channel", 32'(start_req[2]), 32'h0);
        frame_num = 11'd1;
        #1;
        check("R8 odd frame allows odd channel", 32'(start_req[2]), 32'h1);
        step();
    endtask

    task automatic t_budget();
        wr(2, 32'h2000_0000 | (32'h3 << 20) | 32'h0008_0000);
        frame_num = 11'd3;
        step();
        check("R9 request at frame start", 32'(start_req[2]), 32'h1);
        for (int k = 1; k <= 3; k++) begin
            start_ack[2] = 1'b1;
            step();
            start_ack[2] = 1'b0;
            check("R9 count 3 budget", 32'(start_req[2]), (k < 3) ? 32'h1 : 32'h0);
        end
        frame_num = 11'd5;
        #1;
        check("R9 budget refills on new frame", 32'(start_req[2]), 32'h1);
        step();
        wr(2, 32'h2000_0000 | 32'h0008_0000);
        frame_num = 11'd7;
        step();
        check("R9 count 00 allows one", 32'(start_req[2]), 32'h1);
        start_ack[2] = 1'b1;
        step();
        start_ack[2] = 1'b0;
        check("R9 count 00 acts as one", 32'(start_req[2]), 32'h0);
    endtask

    task automatic t_isolation();
        logic [31:0] v;
        logic [31:0] ref3;
        rd(3, ref3);
        wr(4, 32'h8000_0000);
        rd(3, v);
        check("R11 neighbour untouched", v, ref3);
        wr(9, 32'hFFFF_FFFF);
        rd(3, v);
        check("R12 out-of-range write ignored ch3", v, ref3);
        rd(5, v);
        check("R12 out-of-range write ignored ch5", v, 32'h0);
        rd(8, v);
        check("R12 out-of-range write ignored ch8", v, 32'h0);
        rd(9, v);
        check("R12 out-of-range read zero", v, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_data = '0; rd_ch = '0;
        frame_num = '0; xfer_end = '0; start_ack = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_enable_set_only();
        t_fields();
        t_abort_idle();
        t_abort();
        t_complete();
        t_parity();
        t_budget();
        t_isolation();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule